// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces a small processor whose only operation is a move from one source to one destination. A two-bit phase register walks through four phases per instruction: a quiet phase, a fetch phase, a second quiet phase and an execute phase. The two quiet phases keep the fetch and execute strobes apart so they never overlap or glitch into each other. From the phase the block derives a fetch strobe, an execute strobe, a load pulse for the instruction register and an increment request for the program counter. The PC is stepped at the end of every fetch, and again at the end of execute when the decoder reports that the move reads a literal from program memory.

A run/stop register lets a loader freeze the machine so program memory can be filled. A stop request never cuts an instruction short. It takes effect on the wrap from execute back to the first quiet phase. While stopped, the phase high bit is pinned at zero. A synchronized push-button input then flips the low bit once per press. Each flip from fetch back to the quiet phase advances the program counter by one. Program-memory writes are only allowed while stopped in the quiet phase.

Top module: `insn_cycle_seq`

## Requirements
- R1: After reset the block is stopped (`running_o`=0) in phase 0, with `fetch_stb_o`, `exec_stb_o`, `ir_load_o` and `pc_inc_o` all low.
- R2: While running, `phase_o` advances by one every clock in the order 0,1,2,3,0. `fetch_stb_o` is high exactly in phase 1 and `exec_stb_o` exactly in phase 3.
- R3: While running, `ir_load_o` is high for the single cycle of phase 1 of each instruction and low in every other cycle.
- R4: While running, `pc_inc_o` is high in phase 1 of every instruction. It is also high in phase 3 when `src_pmem_i` is 1, and low in phase 3 when `src_pmem_i` is 0. It is low in phases 0 and 2.
- R5: A one-cycle `halt_req_i` pulse while running lets the current instruction finish. `running_o` stays 1 through phase 3 and drops on the clock that returns `phase_o` to 0.
- R6: While stopped and with no step press, `phase_o` does not change and its high bit stays 0.
- R7: While stopped, each rising edge of `step_btn_i` flips `phase_o` between 0 and 1 exactly once, however long the button is held. The flip appears at most four clocks after the edge.
- R8: A step from phase 1 to phase 0 gives exactly one `pc_inc_o` pulse. A step from phase 0 to phase 1 gives none, and stepping never raises `ir_load_o`.
- R9: `pmem_wr_ok_o` is 1 only while stopped in phase 0, and 0 in phase 1 or while running.
- R10: `step_btn_i` has no effect while running; the phase sequence stays as in R2.
- R11: When `run_req_i` and `halt_req_i` are both high in the same cycle while stopped, the block stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_req_i | input | 1 | Start request, acted on while stopped |
| halt_req_i | input | 1 | Stop request, applied at the next wrap to phase 0 |
| step_btn_i | input | 1 | Asynchronous manual step button, active high |
| src_pmem_i | input | 1 | Decoder flag: the executing move reads program memory |
| phase_o | output | 2 | Current phase: 0 idle, 1 fetch, 2 idle, 3 execute |
| fetch_stb_o | output | 1 | Fetch strobe while running |
| exec_stb_o | output | 1 | Execute strobe |
| ir_load_o | output | 1 | Instruction register capture enable |
| pc_inc_o | output | 1 | Program counter increment request |
| pmem_wr_ok_o | output | 1 | External program-memory writes permitted |
| running_o | output | 1 | Run/stop state |

## Verification
Two things can fall on the same execute cycle: the stop taking effect and the literal-read PC increment. The bench raises `halt_req_i` together with `src_pmem_i` in exactly the cycle where phase 3 is showing. It then judges that `pc_inc_o` is still high in that cycle, and that the next cycle shows phase 0 with `running_o` low. A second collision is a start and a stop requested in one cycle while stopped. The stop must win, and the phase must stay where it was.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE0 = 2'd0,
    PH_FETCH = 2'd1,
    PH_IDLE1 = 2'd2,
    PH_EXEC  = 2'd3
  } phase_e;
endpackage

// File: rtl/iseq_rst_sync.sv
module iseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[TOP];
endmodule

// File: rtl/iseq_step_sync.sv
module iseq_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic pulse_o
);
  // STAGES synchronizer flops followed by one history flop for edge detection
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], btn_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pulse_o = sh_q[LAST-1] & ~sh_q[LAST];

  // R7: a held button yields one pulse, never two back to back
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/iseq_run_ctl.sv
module iseq_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req_i,
  input  logic halt_req_i,
  input  logic at_exec_i,
  output logic run_o
);
  logic run_q, run_d;
  logic halt_pend_q, halt_pend_d;
  logic halt_seen;
  logic apply_stop;
  logic start_ok;

  always_comb begin
    halt_seen   = halt_pend_q | halt_req_i;
    apply_stop  = run_q & at_exec_i & halt_seen;
    start_ok    = ~run_q & run_req_i & ~halt_req_i;
    halt_pend_d = run_q & ~apply_stop & halt_seen;
    run_d       = run_q;
    if (apply_stop)    run_d = 1'b0;
    else if (start_ok) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      halt_pend_q <= 1'b0;
    end else begin
      run_q       <= run_d;
      halt_pend_q <= halt_pend_d;
    end
  end

  assign run_o = run_q;

  // R5: a running machine only stops out of the execute phase
  a_r5_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_exec_i) |=> run_q);
  // R5: a pending stop lands on the wrap
  a_r5_stop_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_exec_i && halt_pend_q) |=> !run_q);
  // R11: stop dominates start
  a_r11_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && halt_req_i) |=> !run_q);
endmodule

// File: rtl/iseq_phase_ctr.sv
module iseq_phase_ctr
  import iseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_i,
  input  logic   step_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;
  logic   ph_en;

  always_comb begin
    ph_en   = run_i | step_i;
    phase_d = phase_q;
    if (run_i)       phase_d = phase_e'(phase_q + 2'd1);
    else if (step_i) phase_d = phase_e'({1'b0, ~phase_q[0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= PH_IDLE0;
    else if (ph_en) phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R2: one phase per clock while running
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (phase_q == phase_e'($past(phase_q) + 2'd1)));
  // R6: high bit pinned while stopped
  a_r6_high_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !phase_q[1]);
  // R6: no press, no motion while stopped
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !step_i) |=> $stable(phase_q));
endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
  import iseq_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int STEP_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req_i,
  input  logic       halt_req_i,
  input  logic       step_btn_i,
  input  logic       src_pmem_i,
  output logic [1:0] phase_o,
  output logic       fetch_stb_o,
  output logic       exec_stb_o,
  output logic       ir_load_o,
  output logic       pc_inc_o,
  output logic       pmem_wr_ok_o,
  output logic       running_o
);
  logic   rst_n_s;
  logic   step_pulse;
  logic   run;
  phase_e phase;
  logic   in_fetch, in_exec, in_idle0;

  iseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s));

  iseq_step_sync #(.STAGES(STEP_STAGES)) u_step (
    .clk(clk), .rst_n(rst_n_s), .btn_i(step_btn_i), .pulse_o(step_pulse));

  iseq_run_ctl u_run (
    .clk(clk), .rst_n(rst_n_s), .run_req_i(run_req_i),
    .halt_req_i(halt_req_i), .at_exec_i(in_exec), .run_o(run));

  iseq_phase_ctr u_ph (
    .clk(clk), .rst_n(rst_n_s), .run_i(run), .step_i(step_pulse),
    .phase_o(phase));

  always_comb begin
    in_fetch     = (phase == PH_FETCH);
    in_exec      = (phase == PH_EXEC);
    in_idle0     = (phase == PH_IDLE0);
    fetch_stb_o  = run & in_fetch;
    exec_stb_o   = in_exec;
    ir_load_o    = run & in_fetch;
    pc_inc_o     = (run & (in_fetch | (in_exec & src_pmem_i)))
                 | (~run & step_pulse & in_fetch);
    pmem_wr_ok_o = ~run & in_idle0;
    running_o    = run;
    phase_o      = phase;
  end

  // R4: increments only ever come from phase 1 or phase 3
  a_r4_pcinc_odd: assert property (@(posedge clk) disable iff (!rst_n_s)
    pc_inc_o |-> phase[0]);
  // R3: after a capture the sequencer moves into the second idle phase
  a_r3_irload_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    ir_load_o |=> (phase == PH_IDLE1));
  // R9: write window never overlaps fetch or execute activity
  a_r9_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    pmem_wr_ok_o |-> (!exec_stb_o && !ir_load_o && !fetch_stb_o));
endmodule

// File: tb/insn_cycle_seq_tb_top.sv
module insn_cycle_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic run_req, halt_req, step_btn, src_pmem;
  logic [1:0] phase;
  logic fetch_stb, exec_stb, ir_load, pc_inc, pmem_wr_ok, running;

  int checks = 0;
  int errors = 0;
  int pc_cnt = 0;
  int ir_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run_req_i(run_req), .halt_req_i(halt_req),
    .step_btn_i(step_btn), .src_pmem_i(src_pmem), .phase_o(phase),
    .fetch_stb_o(fetch_stb), .exec_stb_o(exec_stb), .ir_load_o(ir_load),
    .pc_inc_o(pc_inc), .pmem_wr_ok_o(pmem_wr_ok), .running_o(running));

  always @(posedge clk) begin
    if (pc_inc)  pc_cnt++;
    if (ir_load) ir_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset;
    chk("R1 phase", phase, 0);
    chk("R1 running", running, 0);
    chk("R1 fetch", fetch_stb, 0);
    chk("R1 exec", exec_stb, 0);
    chk("R1 irload", ir_load, 0);
    chk("R1 pcinc", pc_inc, 0);
    chk("R9 wr_ok at reset", pmem_wr_ok, 1);
  endtask

  task automatic t_stopped_hold;
    cyc(10);
    chk("R6 phase hold", phase, 0);
    chk("R6 still stopped", running, 0);
  endtask

  // start from phase 0, run 3 instructions, stop cleanly
  task automatic t_run_sequence;
    int pc0, ir0;
    run_req = 1'b1;
    cyc(1);
    run_req = 1'b0;
    pc0 = pc_cnt;
    ir0 = ir_cnt;
    for (int i = 0; i < 12; i++) begin
      src_pmem = ((i / 4) % 2) == 1;
      #1;
      chk("R2 phase", phase, i % 4);
      chk("R2 fetch", fetch_stb, (i % 4) == 1);
      chk("R2 exec", exec_stb, (i % 4) == 3);
      chk("R3 irload", ir_load, (i % 4) == 1);
      chk("R4 pcinc", pc_inc, ((i % 4) == 1) || (((i % 4) == 3) && src_pmem));
      chk("R9 wr_ok running", pmem_wr_ok, 0);
      cyc(1);
    end
    chk("R4 pcinc total", pc_cnt - pc0, 4);
    chk("R3 irload total", ir_cnt - ir0, 3);
    src_pmem = 1'b0;
  endtask

  // running, phase 0 currently: halt during fetch
  task automatic t_halt_midway;
    cyc(1);
    chk("R5 in fetch", phase, 1);
    halt_req = 1'b1;
    cyc(1);
    halt_req = 1'b0;
    chk("R5 running in phase 2", running, 1);
    chk("R5 phase 2", phase, 2);
    cyc(1);
    chk("R5 running in phase 3", running, 1);
    cyc(1);
    chk("R5 stopped at wrap", running, 0);
    chk("R5 phase 0", phase, 0);
    cyc(6);
    chk("R6 stays 0", phase, 0);
    chk("R9 wr_ok stopped", pmem_wr_ok, 1);
  endtask

  // halt and literal increment in the same execute cycle
  task automatic t_halt_with_literal;
    run_req = 1'b1;
    cyc(1);
    run_req = 1'b0;
    cyc(3);
    chk("R2 reach exec", phase, 3);
    halt_req = 1'b1;
    src_pmem = 1'b1;
    #1;
    chk("R4 literal inc with halt", pc_inc, 1);
    cyc(1);
    halt_req = 1'b0;
    src_pmem = 1'b0;
    chk("R5 stopped after exec", running, 0);
    chk("R5 phase 0 after exec", phase, 0);
  endtask

  task automatic t_step;
    int pc0, ir0;
    pc0 = pc_cnt;
    ir0 = ir_cnt;
    step_btn = 1'b1;
    cyc(5);
    chk("R7 step to 1", phase, 1);
    chk("R8 no inc 0->1", pc_cnt - pc0, 0);
    chk("R9 wr_ok phase 1", pmem_wr_ok, 0);
    cyc(10);
    chk("R7 held no repeat", phase, 1);
    step_btn = 1'b0;
    cyc(4);
    step_btn = 1'b1;
    cyc(5);
    chk("R7 step to 0", phase, 0);
    chk("R8 one inc 1->0", pc_cnt - pc0, 1);
    chk("R8 no irload", ir_cnt - ir0, 0);
    chk("R9 wr_ok back", pmem_wr_ok, 1);
    step_btn = 1'b0;
    cyc(4);
  endtask

  task automatic t_step_while_running;
    int p0;
    run_req = 1'b1;
    cyc(1);
    run_req = 1'b0;
    p0 = phase;
    step_btn = 1'b1;
    cyc(4);
    step_btn = 1'b0;
    cyc(4);
    chk("R10 phase unaffected", phase, p0);
    chk("R10 still running", running, 1);
    halt_req = 1'b1;
    cyc(1);
    halt_req = 1'b0;
    cyc(4);
    chk("R10 stopped again", running, 0);
  endtask

  task automatic t_run_halt_same;
    run_req = 1'b1;
    halt_req = 1'b1;
    cyc(1);
    run_req = 1'b0;
    halt_req = 1'b0;
    cyc(5);
    chk("R11 stays stopped", running, 0);
    chk("R11 phase unchanged", phase, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    run_req = 1'b0;
    halt_req = 1'b0;
    step_btn = 1'b0;
    src_pmem = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_stopped_hold();
    t_run_sequence();
    t_halt_midway();
    t_halt_with_literal();
    t_step();
    t_step_while_running();
    t_run_halt_same();
    done = 1'b1;
    report();
  end
endmodule